// File: doc/BRIEF.md
# Event Comparator and Trigger Sequencer

This block decides when an on-chip logic analyzer should stop waiting and capture. It watches a probe bus made of several equal-width lanes. Two event channels, EV0 and EV1, each pick one lane and compare it with a programmed reference value using a selectable relational operator. Each channel also has an occurrence counter, so an event can be made to need several matching samples before it counts.

A condition selector combines the two channels in one of three ways. It can fire on EV0 alone. It can fire when EV0 and EV1 are true in the same cycle. It can first wait for EV1 and then wait for EV0. An external trigger input, with its own enable and polarity, can also fire the block. A fire produces a single registered pulse on the trigger output, whose polarity is programmable. After that the block stays quiet until it is armed again.

The probe bus carries a qualifier, `probe_valid`, and nothing else. The block cannot stall the source, so there is no ready signal and no back-pressure: a cycle with `probe_valid` low is simply not a sample. Configuration inputs are plain levels. They are expected to hold still while the block is armed.

Top module: `trig_seq_top`

## Requirements
- R1: After reset the block is disarmed and `trig_out` sits at its inactive level, which is equal to `out_pol`.
- R2: Operator codes act on unsigned values: 0 equal, 1 not equal, 2 greater than, 3 less than, 4 greater or equal, 5 less or equal. The comparison is always lane value against reference. Codes 6 and 7 never match. Lane k is `probe_data[k*PROBE_W +: PROBE_W]`.
- R3: A cycle with `probe_valid` low produces no match and does not advance any counter.
- R4: An event occurs on the matching sample that is the Nth one since arming, where N is the channel's count setting and 0 is treated as 1. Every later match also counts as an occurrence, because the counter saturates.
- R5: Condition code 0 fires on an EV0 occurrence.
- R6: Condition code 1 fires only when EV0 and EV1 occur in the same cycle.
- R7: Condition code 2 records an EV1 occurrence in a latch. From the next cycle on, EV0 is counted and evaluated, and an EV0 occurrence then fires the block. Arming clears the latch. Condition code 3 never fires from the internal events.
- R8: When `ext_en` is high, the input `trig_in` XOR `ext_pol` is ORed into the fire condition. Setting `ext_pol` to 1 makes `trig_in` active low.
- R9: A fire in a cycle makes `trig_out` active, meaning the inverse of `out_pol`, for exactly the following cycle.
- R10: A fire disarms the block. No further pulse appears until `arm` is pulsed again.
- R11: A cycle with `arm` high clears both counters and the sequence latch. It suppresses any fire in that same cycle, and the block is armed from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_valid | input | 1 | Probe sample qualifier |
| probe_data | input | NLANE*PROBE_W | Probe lanes |
| ev0_lane | input | LANE_W | Lane picked by EV0 |
| ev0_op | input | 3 | EV0 operator code |
| ev0_ref | input | PROBE_W | EV0 reference value |
| ev0_count | input | CNT_W | EV0 occurrences required |
| ev1_lane | input | LANE_W | Lane picked by EV1 |
| ev1_op | input | 3 | EV1 operator code |
| ev1_ref | input | PROBE_W | EV1 reference value |
| ev1_count | input | CNT_W | EV1 occurrences required |
| cond_mode | input | 2 | Condition code |
| arm | input | 1 | Re-arm strobe |
| ext_en | input | 1 | External trigger enable |
| ext_pol | input | 1 | External trigger polarity, 1 = active low |
| trig_in | input | 1 | External trigger |
| out_pol | input | 1 | Output polarity, 1 = active low |
| trig_out | output | 1 | Trigger pulse |

## Verification
Two functions can land in the same cycle. A re-arm strobe can arrive together with a fire condition that is already true. The sequence latch can also set in the same cycle that EV0 matches. The bench provokes both cases on purpose. It holds `arm` high while the lanes match, and it presents the EV1 and EV0 matches together on the first armed cycle. The expected result is no pulse after those edges, followed by a pulse one cycle after the next qualifying sample. Random episodes then mix in re-arms and external pulses at random points against a cycle model in the bench.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam logic [2:0] OP_EQ = 3'd0;
  localparam logic [2:0] OP_NE = 3'd1;
  localparam logic [2:0] OP_GT = 3'd2;
  localparam logic [2:0] OP_LT = 3'd3;
  localparam logic [2:0] OP_GE = 3'd4;
  localparam logic [2:0] OP_LE = 3'd5;

  typedef enum logic [1:0] {
    MODE_EV0  = 2'd0,
    MODE_BOTH = 2'd1,
    MODE_SEQ  = 2'd2,
    MODE_OFF  = 2'd3
  } cond_mode_e;

  localparam int NUM_EV = 2;
endpackage

// File: rtl/trig_cmp.sv
module trig_cmp
  import trig_seq_pkg::*;
#(
  parameter int W      = 8,
  parameter bit MAG_EN = 1'b1
) (
  input  logic         valid,
  input  logic [W-1:0] val,
  input  logic [W-1:0] refv,
  input  logic [2:0]   op,
  output logic         hit
);
  logic is_eq, is_gt, is_lt;

  assign is_eq = (val == refv);
  assign is_gt = (val > refv);
  assign is_lt = (val < refv);

  generate
    if (MAG_EN) begin : g_mag
      logic rel;
      always_comb begin
        case (op)
          OP_EQ:   rel = is_eq;
          OP_NE:   rel = !is_eq;
          OP_GT:   rel = is_gt;
          OP_LT:   rel = is_lt;
          OP_GE:   rel = !is_lt;
          OP_LE:   rel = !is_gt;
          default: rel = 1'b0;
        endcase
      end
      assign hit = valid && rel;
    end else begin : g_eq_only
      logic unused_rel;
      assign unused_rel = is_gt ^ is_lt;
      assign hit = valid && (op == OP_EQ) && is_eq;
    end
  endgenerate
endmodule

// File: rtl/trig_evcnt.sv
module trig_evcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             hit,
  input  logic [CNT_W-1:0] target,
  output logic             ev_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   next_cnt;
  logic [CNT_W:0]   need;

  assign need     = (target == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, target};
  assign next_cnt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign ev_now   = en && hit && (next_cnt >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en && hit && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trig_seq_ctl.sv
module trig_seq_ctl
  import trig_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [1:0] mode,
  input  logic       ev0_now,
  input  logic       ev1_now,
  input  logic       ext_hit,
  output logic       ev0_en,
  output logic       ev1_en,
  output logic       fire,
  output logic       pulse,
  output logic       armed,
  output logic       seq_latch
);
  cond_mode_e mode_e;
  logic       cond;
  logic       armed_q, seq_q, pulse_q;

  assign mode_e = cond_mode_e'(mode);

  always_comb begin
    case (mode_e)
      MODE_EV0:  cond = ev0_now;
      MODE_BOTH: cond = ev0_now && ev1_now;
      MODE_SEQ:  cond = seq_q && ev0_now;
      default:   cond = 1'b0;
    endcase
  end

  assign ev0_en = armed_q && ((mode_e != MODE_SEQ) || seq_q);
  assign ev1_en = armed_q;
  assign fire   = armed_q && !arm && (cond || ext_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (arm)       armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
      if (arm)
        seq_q <= 1'b0;
      else if (armed_q && (mode_e == MODE_SEQ) && ev1_now)
        seq_q <= 1'b1;
    end
  end

  assign pulse     = pulse_q;
  assign armed     = armed_q;
  assign seq_latch = seq_q;
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
  import trig_seq_pkg::*;
#(
  parameter int NLANE   = 4,
  parameter int PROBE_W = 8,
  parameter int CNT_W   = 4,
  parameter bit MAG_EN  = 1'b1,
  parameter bit EXT_EN  = 1'b1,
  localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     probe_valid,
  input  logic [NLANE*PROBE_W-1:0] probe_data,
  input  logic [LANE_W-1:0]        ev0_lane,
  input  logic [2:0]               ev0_op,
  input  logic [PROBE_W-1:0]       ev0_ref,
  input  logic [CNT_W-1:0]         ev0_count,
  input  logic [LANE_W-1:0]        ev1_lane,
  input  logic [2:0]               ev1_op,
  input  logic [PROBE_W-1:0]       ev1_ref,
  input  logic [CNT_W-1:0]         ev1_count,
  input  logic [1:0]               cond_mode,
  input  logic                     arm,
  input  logic                     ext_en,
  input  logic                     ext_pol,
  input  logic                     trig_in,
  input  logic                     out_pol,
  output logic                     trig_out
);
  logic [PROBE_W-1:0] lanes   [NLANE];
  logic [LANE_W-1:0]  sel     [NUM_EV];
  logic [2:0]         op      [NUM_EV];
  logic [PROBE_W-1:0] refv    [NUM_EV];
  logic [CNT_W-1:0]   target  [NUM_EV];
  logic [NUM_EV-1:0]  hit, ev_en, ev_now;
  logic               ext_hit, fire, pulse_q, armed_q, seq_q;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign lanes[k] = probe_data[k*PROBE_W +: PROBE_W];
  end

  assign sel[0] = ev0_lane;  assign sel[1] = ev1_lane;
  assign op[0]  = ev0_op;    assign op[1]  = ev1_op;
  assign refv[0] = ev0_ref;  assign refv[1] = ev1_ref;
  assign target[0] = ev0_count; assign target[1] = ev1_count;

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    logic [PROBE_W-1:0] picked;
    always_comb begin
      picked = '0;
      for (int k = 0; k < NLANE; k++)
        if (sel[e] == LANE_W'(k)) picked = lanes[k];
    end

    trig_cmp #(.W(PROBE_W), .MAG_EN(MAG_EN)) u_cmp (
      .valid (probe_valid),
      .val   (picked),
      .refv  (refv[e]),
      .op    (op[e]),
      .hit   (hit[e])
    );

    trig_evcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (arm),
      .en     (ev_en[e]),
      .hit    (hit[e]),
      .target (target[e]),
      .ev_now (ev_now[e])
    );
  end

  generate
    if (EXT_EN) begin : g_ext
      assign ext_hit = ext_en && (trig_in ^ ext_pol);
    end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_en ^ ext_pol ^ trig_in;
      assign ext_hit = 1'b0;
    end
  endgenerate

  trig_seq_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .mode      (cond_mode),
    .ev0_now   (ev_now[0]),
    .ev1_now   (ev_now[1]),
    .ext_hit   (ext_hit),
    .ev0_en    (ev_en[0]),
    .ev1_en    (ev_en[1]),
    .fire      (fire),
    .pulse     (pulse_q),
    .armed     (armed_q),
    .seq_latch (seq_q)
  );

  assign trig_out = pulse_q ^ out_pol;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic [1:0] cond_mode,
  input logic       ext_hit,
  input logic       fire,
  input logic       pulse,
  input logic       armed,
  input logic       seq_latch
);
  // R9: a fire is followed by the pulse in the next cycle
  a_r9_pulse_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);
  // R9: the pulse lasts exactly one cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R10: while the pulse is out, the block is already disarmed
  a_r10_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !$past(arm)) |-> !armed);
  // R11: an arm cycle never produces a pulse after its edge
  a_r11_arm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !pulse);
  // R11: arming clears the sequence latch
  a_r11_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !seq_latch);
  // R7: in sequence mode an internal fire needs the latch set
  a_r7_seq_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ext_hit && cond_mode == 2'd2) |-> seq_latch);
  // R8: an armed block with an external hit fires
  a_r8_ext_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !arm && ext_hit) |=> pulse);
endmodule

bind trig_seq_top trig_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .cond_mode (cond_mode),
  .ext_hit   (ext_hit),
  .fire      (fire),
  .pulse     (pulse_q),
  .armed     (armed_q),
  .seq_latch (seq_q)
);

// File: tb/trig_seq_top_bench.sv
module trig_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NLANE = 4, PW = 8, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic probe_valid = 1'b0;
  logic [PW-1:0] lane_v [NLANE];
  logic [NLANE*PW-1:0] probe_data;
  logic [1:0] ev0_lane = '0, ev1_lane = '0, cond_mode = '0;
  logic [2:0] ev0_op = '0, ev1_op = '0;
  logic [PW-1:0] ev0_ref = '0, ev1_ref = '0;
  logic [CW-1:0] ev0_count = '0, ev1_count = '0;
  logic arm = 1'b0, ext_en = 1'b0, ext_pol = 1'b0, trig_in = 1'b0, out_pol = 1'b0;
  logic trig_out;

  int n_chk = 0, n_fail = 0;

  assign probe_data = {lane_v[3], lane_v[2], lane_v[1], lane_v[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_seq_top u_trig_seq_top (
    .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_data(probe_data),
    .ev0_lane(ev0_lane), .ev0_op(ev0_op), .ev0_ref(ev0_ref), .ev0_count(ev0_count),
    .ev1_lane(ev1_lane), .ev1_op(ev1_op), .ev1_ref(ev1_ref), .ev1_count(ev1_count),
    .cond_mode(cond_mode), .arm(arm), .ext_en(ext_en), .ext_pol(ext_pol),
    .trig_in(trig_in), .out_pol(out_pol), .trig_out(trig_out));

  // bench model state
  logic m_armed = 0, m_latch = 0, m_pulse = 0;
  int   m_c0 = 0, m_c1 = 0;

  function automatic logic cmpf(logic [2:0] o, logic [PW-1:0] v, logic [PW-1:0] r);
    case (o)
      3'd0: return v == r;
      3'd1: return v != r;
      3'd2: return v > r;
      3'd3: return v < r;
      3'd4: return v >= r;
      3'd5: return v <= r;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int need(logic [CW-1:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trig_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic h0, h1, n0, n1, en0, cond, ext, fire;
    h0  = probe_valid && cmpf(ev0_op, lane_v[ev0_lane], ev0_ref);
    h1  = probe_valid && cmpf(ev1_op, lane_v[ev1_lane], ev1_ref);
    en0 = m_armed && (cond_mode != 2'd2 || m_latch);
    n0  = en0 && h0 && (m_c0 + 1 >= need(ev0_count));
    n1  = m_armed && h1 && (m_c1 + 1 >= need(ev1_count));
    case (cond_mode)
      2'd0: cond = n0;
      2'd1: cond = n0 && n1;
      2'd2: cond = m_latch && n0;
      default: cond = 1'b0;
    endcase
    ext  = ext_en && (trig_in ^ ext_pol);
    fire = m_armed && !arm && (cond || ext);
    if (arm) begin
      m_armed = 1; m_c0 = 0; m_c1 = 0; m_latch = 0;
    end else begin
      if (en0 && h0 && m_c0 < 15) m_c0++;
      if (m_armed && h1 && m_c1 < 15) m_c1++;
      if (m_armed && cond_mode == 2'd2 && n1) m_latch = 1;
      if (fire) m_armed = 0;
    end
    m_pulse = fire;
  endtask

  // one clock: inputs already driven off-edge; check against model after edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    #1;
    chk(tag, trig_out, m_pulse ^ out_pol);
  endtask

  task automatic idle_lanes();
    for (int k = 0; k < NLANE; k++) lane_v[k] = 8'hF0;
  endtask

  task automatic do_arm(string tag);
    arm = 1; cyc(tag); arm = 0;
  endtask

  // arm, present one sample, check the pulse
  task automatic try_op(string tag, logic [2:0] o, logic [PW-1:0] v, logic vld, logic exp);
    cond_mode = 2'd0; ev0_lane = 2'd2; ev0_ref = 8'd5; ev0_op = o; ev0_count = 0;
    idle_lanes(); probe_valid = 0;
    do_arm(tag);
    lane_v[2] = v; probe_valid = vld;
    cyc(tag);
    probe_valid = 0;
    cyc(tag);
    chk(tag, trig_out, out_pol);
    // pulse was one cycle before: compare via model already; explicit check
    n_chk++;
    if (m_pulse !== 1'b0) begin n_fail++; $display("FAIL %s: extra pulse", tag); end
    if (exp) ; // expectation applied below
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, act=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_lanes();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", trig_out, 1'b0);
    rst_n = 1;
    #(CLK_PERIOD);
    chk("R1", trig_out, out_pol);

    // R2 / R3 directed operator checks with hand expectations
    begin
      logic [2:0] ops [9] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd2, 3'd6, 3'd0};
      logic [7:0] vals[9] = '{8'd5, 8'd5, 8'd7, 8'd7, 8'd5, 8'd4, 8'd5, 8'd5, 8'd5};
      logic       vld [9] = '{1, 1, 1, 1, 1, 1, 1, 1, 0};
      logic       exps[9] = '{1, 0, 1, 0, 1, 1, 0, 0, 0};
      for (int i = 0; i < 9; i++) begin
        cond_mode = 2'd0; ev0_lane = 2'd2; ev0_ref = 8'd5; ev0_op = ops[i]; ev0_count = 0;
        idle_lanes(); probe_valid = 0;
        do_arm("R2");
        lane_v[2] = vals[i]; probe_valid = vld[i];
        cyc(i == 8 ? "R3" : "R2");
        chk(i == 8 ? "R3" : "R2", trig_out, exps[i]);
        probe_valid = 0;
        cyc("R9");
        chk("R9", trig_out, 1'b0);
      end
    end

    // R4 count of three, then R10 blocked
    cond_mode = 2'd0; ev0_lane = 2'd1; ev0_op = 3'd0; ev0_ref = 8'd9; ev0_count = 4'd3;
    idle_lanes(); probe_valid = 0;
    do_arm("R4");
    lane_v[1] = 8'd9; probe_valid = 1;
    cyc("R4"); chk("R4", trig_out, 1'b0);
    cyc("R4"); chk("R4", trig_out, 1'b0);
    cyc("R4"); chk("R4", trig_out, 1'b1);
    cyc("R10"); chk("R10", trig_out, 1'b0);
    cyc("R10"); chk("R10", trig_out, 1'b0);
    probe_valid = 0;

    // R7 sequence: EV1 and EV0 together on first armed cycle must not fire
    cond_mode = 2'd2; ev0_count = 0; ev1_count = 0;
    ev0_lane = 2'd0; ev0_op = 3'd0; ev0_ref = 8'd1;
    ev1_lane = 2'd3; ev1_op = 3'd0; ev1_ref = 8'd2;
    idle_lanes();
    do_arm("R7");
    lane_v[0] = 8'd1; lane_v[3] = 8'd2; probe_valid = 1;
    cyc("R7"); chk("R7", trig_out, 1'b0);
    lane_v[3] = 8'hF0;
    cyc("R7"); chk("R7", trig_out, 1'b1);
    probe_valid = 0;

    // R6 both together
    cond_mode = 2'd1;
    do_arm("R6");
    lane_v[0] = 8'd1; lane_v[3] = 8'hF0; probe_valid = 1;
    cyc("R6"); chk("R6", trig_out, 1'b0);
    lane_v[3] = 8'd2;
    cyc("R6"); chk("R6", trig_out, 1'b1);
    probe_valid = 0; idle_lanes();

    // R8 external trigger, active low; R9 inverted output polarity
    cond_mode = 2'd3; ext_en = 1; ext_pol = 1; trig_in = 1; out_pol = 1;
    do_arm("R8");
    cyc("R9"); chk("R9", trig_out, 1'b1);
    trig_in = 0;
    cyc("R8"); chk("R8", trig_out, 1'b0);
    cyc("R9"); chk("R9", trig_out, 1'b1);
    trig_in = 1; ext_en = 0; ext_pol = 0; out_pol = 0;

    // R11 arm coinciding with a true condition
    cond_mode = 2'd0; ev0_lane = 2'd0; ev0_op = 3'd0; ev0_ref = 8'd1; ev0_count = 0;
    do_arm("R11");
    lane_v[0] = 8'd1; probe_valid = 1; arm = 1;
    cyc("R11"); chk("R11", trig_out, 1'b0);
    arm = 0;
    cyc("R11"); chk("R11", trig_out, 1'b1);
    probe_valid = 0; idle_lanes(); trig_in = 0;

    // random episodes against the model
    for (int ep = 0; ep < 40; ep++) begin
      string tag;
      cond_mode = 2'($urandom_range(0, 3));
      ev0_op = 3'($urandom_range(0, 7)); ev1_op = 3'($urandom_range(0, 7));
      ev0_lane = 2'($urandom_range(0, 3)); ev1_lane = 2'($urandom_range(0, 3));
      ev0_ref = 8'($urandom_range(0, 3)); ev1_ref = 8'($urandom_range(0, 3));
      ev0_count = 4'($urandom_range(0, 3)); ev1_count = 4'($urandom_range(0, 3));
      ext_en = 1'($urandom_range(0, 1)); ext_pol = 1'($urandom_range(0, 1));
      out_pol = 1'($urandom_range(0, 1));
      trig_in = ext_pol;
      case (cond_mode)
        2'd0: tag = "R5";
        2'd1: tag = "R6";
        default: tag = "R7";
      endcase
      if (ext_en) tag = "R8";
      do_arm(tag);
      for (int c = 0; c < 120; c++) begin
        for (int k = 0; k < NLANE; k++) lane_v[k] = 8'($urandom_range(0, 3));
        probe_valid = ($urandom_range(0, 7) != 0);
        arm = ($urandom_range(0, 29) == 0);
        trig_in = ext_pol ^ ($urandom_range(0, 39) == 0);
        cyc(tag);
      end
      arm = 0; probe_valid = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule